// File: doc/BRIEF.md
# Bus Security Filter

This block sits on the path from one bus master to one memory or peripheral target. Each request carries a tag that marks it secure or non-secure. A region table outside the block returns an attribute for the address on the request, and the filter compares the tag with that attribute. A non-secure request that hits a secure region is illegal. Legal requests reach the target in the same cycle, with no wait states added.

An illegal request never reaches the target, and the master's handshake still completes. A suppressed write is dropped. A suppressed read returns zero on the normal return path. Each violation produces a one-cycle pulse on either the interrupt request or the reset request, depending on a configuration input. A register holds the address of the first violation until software clears it.

Regions marked exempt are not checked. In a multi-beat transfer, the first illegal beat ends forwarding, and every later beat up to the last beat is absorbed.

Top module: `bus_sec_filter`

## Requirements
- R1: A legal request is forwarded in the same cycle. `t_valid` equals `m_valid`, and `t_addr`, `t_write` and `t_wdata` equal the master's fields. `m_ready` follows `t_ready`, so no wait state is added.
- R2: A request with `m_secure`=1 is legal for any target, including a target with `attr_secure`=1.
- R3: A request is illegal when `m_secure`=0, `attr_secure`=1 and `attr_exempt`=0. An illegal request keeps `t_valid` low, and `m_ready` is 1 in that same cycle whatever the value of `t_ready`.
- R4: Reads use a fixed latency of one cycle. In the cycle after an accepted read, `m_rvalid` is 1. `m_rdata` equals `t_rdata` for a forwarded read and is all zeros for a suppressed read.
- R5: When `attr_exempt`=1, the request is forwarded and no violation is raised, whatever the tag and `attr_secure`.
- R6: A violating beat produces a one-cycle pulse in the following cycle. The pulse is on `nmi_req` when `cfg_viol_rst`=0 and on `rst_req` when `cfg_viol_rst`=1. The two outputs are never high together.
- R7: An illegal beat with `m_last`=0 starts an abort. It and every following beat up to and including the beat with `m_last`=1 are suppressed, and only the first of them raises a pulse. Beats accepted before the illegal beat were forwarded. A transfer whose first beat is illegal forwards nothing.
- R8: The first violation sets `viol_seen` and records its address in `viol_addr` one cycle after the beat. Later violations leave both unchanged. `viol_clr` clears `viol_seen`. If a clear and a violation fall in the same cycle, the new address is recorded and `viol_seen` stays set.
- R9: After reset, `m_rvalid`, `nmi_req`, `rst_req` and `viol_seen` are 0, and the block is not in an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_viol_rst | input | 1 | Violation signalling: 1 selects the reset request, 0 selects the interrupt request |
| viol_clr | input | 1 | Clears the violation record |
| m_valid | input | 1 | Master request valid |
| m_ready | output | 1 | Request accepted |
| m_addr | input | ADDR_W | Request address |
| m_write | input | 1 | 1 = write, 0 = read |
| m_wdata | input | DATA_W | Write data |
| m_secure | input | 1 | Security tag: 1 = secure |
| m_last | input | 1 | Last beat of a transfer |
| m_rvalid | output | 1 | Read data valid, one cycle after the read is accepted |
| m_rdata | output | DATA_W | Read data returned to the master |
| attr_secure | input | 1 | The region at `m_addr` is secure |
| attr_exempt | input | 1 | The region at `m_addr` is exempt from checking |
| t_valid | output | 1 | Request valid to the target |
| t_ready | input | 1 | Target accepts the request |
| t_addr | output | ADDR_W | Address to the target |
| t_write | output | 1 | Write flag to the target |
| t_wdata | output | DATA_W | Write data to the target |
| t_rdata | input | DATA_W | Target read data, one cycle after the read is accepted |
| nmi_req | output | 1 | Violation pulse, interrupt form |
| rst_req | output | 1 | Violation pulse, reset form |
| viol_seen | output | 1 | A violation has been recorded |
| viol_addr | output | ADDR_W | Address of the recorded violation |

## Verification
Two functions can act in the same cycle: a software clear of the violation record and the capture of a new violation. The bench provokes this by asserting `viol_clr` in the same cycle as an illegal beat. It then expects `viol_seen` to remain 1 and `viol_addr` to hold the new address, rather than an empty record. A second overlap also needs care: an abort that is already running and an illegal beat inside it. The bench checks that only one pulse appears for the whole transfer.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    // Next-state bundle for the beat-level control.
    typedef struct packed {
        logic blk;      // absorbing the remainder of an aborted transfer
        logic rd_pend;  // a read was accepted in the previous cycle
        logic rd_zero;  // that read was suppressed
        logic nmi;      // interrupt-form violation pulse
        logic rst;      // reset-form violation pulse
    } ctl_t;

    localparam ctl_t CTL_RESET = '{blk: 1'b0, rd_pend: 1'b0, rd_zero: 1'b0,
                                   nmi: 1'b0, rst: 1'b0};

endpackage

// File: rtl/sbf_rule.sv
module sbf_rule (
    input  logic tag_secure,
    input  logic reg_secure,
    input  logic reg_exempt,
    output logic illegal
);
    // Only a non-secure request hitting a secure, non-exempt region is refused.
    always_comb begin
        illegal = 1'b0;
        if (!reg_exempt && reg_secure && !tag_secure) begin
            illegal = 1'b1;
        end
    end
endmodule

// File: rtl/sbf_log.sv
module sbf_log #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              event_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              clr_i,
    output logic              seen_o,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } log_t;

    log_t log_d, log_q;

    always_comb begin
        log_d = log_q;
        if (event_i && (!log_q.vld || clr_i)) begin
            log_d.vld  = 1'b1;
            log_d.addr = addr_i;
        end else if (clr_i) begin
            log_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            log_q <= '0;
        end else begin
            log_q <= log_d;
        end
    end

    assign seen_o = log_q.vld;
    assign addr_o = log_q.addr;

    AST_LOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (log_q.vld && !clr_i) |=> $stable(log_q.addr)); // R8

    AST_LOG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        event_i |=> log_q.vld); // R8
endmodule

// File: rtl/bus_sec_filter.sv
module bus_sec_filter #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_viol_rst,
    input  logic              viol_clr,
    input  logic              m_valid,
    output logic              m_ready,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              m_write,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic              m_secure,
    input  logic              m_last,
    output logic              m_rvalid,
    output logic [DATA_W-1:0] m_rdata,
    input  logic              attr_secure,
    input  logic              attr_exempt,
    output logic              t_valid,
    input  logic              t_ready,
    output logic [ADDR_W-1:0] t_addr,
    output logic              t_write,
    output logic [DATA_W-1:0] t_wdata,
    input  logic [DATA_W-1:0] t_rdata,
    output logic              nmi_req,
    output logic              rst_req,
    output logic              viol_seen,
    output logic [ADDR_W-1:0] viol_addr
);
    import sbf_pkg::*;

    ctl_t ctl_d, ctl_q;
    logic illegal;
    logic suppress;
    logic accept;
    logic viol_evt;

    sbf_rule u_rule (
        .tag_secure (m_secure),
        .reg_secure (attr_secure),
        .reg_exempt (attr_exempt),
        .illegal    (illegal)
    );

    // A beat is dropped when it is illegal itself or falls inside an abort.
    assign suppress = illegal || ctl_q.blk;
    assign t_valid  = m_valid && !suppress;
    assign t_addr   = m_addr;
    assign t_write  = m_write;
    assign t_wdata  = m_wdata;
    assign m_ready  = suppress ? 1'b1 : t_ready;
    assign accept   = m_valid && m_ready;
    assign viol_evt = accept && illegal && !ctl_q.blk;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.rd_pend = accept && !m_write;
        ctl_d.rd_zero = accept && !m_write && suppress;
        ctl_d.nmi     = viol_evt && !cfg_viol_rst;
        ctl_d.rst     = viol_evt && cfg_viol_rst;
        if (accept) begin
            ctl_d.blk = suppress && !m_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign m_rvalid = ctl_q.rd_pend;
    assign m_rdata  = ctl_q.rd_zero ? '0 : t_rdata;
    assign nmi_req  = ctl_q.nmi;
    assign rst_req  = ctl_q.rst;

    sbf_log #(.ADDR_W(ADDR_W)) u_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (viol_evt),
        .addr_i  (m_addr),
        .clr_i   (viol_clr),
        .seen_o  (viol_seen),
        .addr_o  (viol_addr)
    );

    AST_NO_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (t_valid && !m_secure && !attr_exempt) |-> !attr_secure); // R3

    AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !t_valid) |-> m_ready); // R3

    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(m_valid && m_ready && !m_write && !m_secure && attr_secure && !attr_exempt)
        |-> (m_rvalid && m_rdata == '0)); // R4

    AST_ONE_SIGNAL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nmi_req, rst_req})); // R6

    AST_EXEMPT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && attr_exempt && !ctl_q.blk) |-> t_valid); // R5
endmodule

// File: tb/sim_bus_sec_filter.sv
module sim_bus_sec_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_viol_rst = 1'b0;
    logic        viol_clr = 1'b0;
    logic        m_valid = 1'b0;
    logic        m_ready;
    logic [31:0] m_addr = '0;
    logic        m_write = 1'b0;
    logic [31:0] m_wdata = '0;
    logic        m_secure = 1'b0;
    logic        m_last = 1'b1;
    logic        m_rvalid;
    logic [31:0] m_rdata;
    logic        attr_secure = 1'b0;
    logic        attr_exempt = 1'b0;
    logic        t_valid;
    logic        t_ready = 1'b1;
    logic [31:0] t_addr;
    logic        t_write;
    logic [31:0] t_wdata;
    logic [31:0] t_rdata = 32'hA5C3_9E17;
    logic        nmi_req;
    logic        rst_req;
    logic        viol_seen;
    logic [31:0] viol_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bus_sec_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_viol_rst(cfg_viol_rst), .viol_clr(viol_clr),
        .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_write(m_write),
        .m_wdata(m_wdata), .m_secure(m_secure), .m_last(m_last),
        .m_rvalid(m_rvalid), .m_rdata(m_rdata),
        .attr_secure(attr_secure), .attr_exempt(attr_exempt),
        .t_valid(t_valid), .t_ready(t_ready), .t_addr(t_addr), .t_write(t_write),
        .t_wdata(t_wdata), .t_rdata(t_rdata),
        .nmi_req(nmi_req), .rst_req(rst_req), .viol_seen(viol_seen), .viol_addr(viol_addr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Present one beat, then wait #3 so the combinational outputs can be checked.
    task automatic put(input logic [31:0] a, input logic w, input logic [31:0] d,
                       input logic s, input logic last, input logic asec, input logic aex);
        m_valid = 1'b1; m_addr = a; m_write = w; m_wdata = d; m_secure = s;
        m_last = last; attr_secure = asec; attr_exempt = aex;
        #3;
    endtask

    // Cross the edge and sample one time unit after it.
    task automatic step();
        @(posedge clk); #1;
        m_valid = 1'b0; viol_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 m_rvalid", m_rvalid, 0);
        chk("R9 nmi_req", nmi_req, 0);
        chk("R9 rst_req", rst_req, 0);
        chk("R9 viol_seen", viol_seen, 0);
        put(32'h100, 1, 32'h1, 0, 1, 0, 0);
        chk("R9 no abort at start", t_valid, 1);
        step();
    endtask

    task automatic t_legal();
        t_ready = 1'b0;
        put(32'h2000, 1, 32'hDEAD_BEEF, 0, 1, 0, 0);
        chk("R1 t_valid", t_valid, 1);
        chk("R1 t_addr", t_addr, 32'h2000);
        chk("R1 t_wdata", t_wdata, 32'hDEAD_BEEF);
        chk("R1 t_write", t_write, 1);
        chk("R1 ready follows target low", m_ready, 0);
        t_ready = 1'b1; #1;
        chk("R1 ready follows target high", m_ready, 1);
        step();
        chk("R1 no pulse", {nmi_req, rst_req}, 0);
        put(32'h3000, 0, 0, 1, 1, 1, 0);
        chk("R2 secure tag to secure target", t_valid, 1);
        step();
        chk("R4 legal rvalid", m_rvalid, 1);
        chk("R4 legal rdata", m_rdata, 32'hA5C3_9E17);
        chk("R2 no pulse", {nmi_req, rst_req}, 0);
    endtask

    task automatic t_illegal();
        t_ready = 1'b0;
        put(32'h4440, 1, 32'h55, 0, 1, 1, 0);
        chk("R3 write blocked", t_valid, 0);
        chk("R3 handshake completes", m_ready, 1);
        t_ready = 1'b1;
        step();
        chk("R6 nmi pulse", nmi_req, 1);
        chk("R6 rst quiet", rst_req, 0);
        chk("R8 seen", viol_seen, 1);
        chk("R8 addr", viol_addr, 32'h4440);
        chk("R4 write gives no rvalid", m_rvalid, 0);
        put(32'h5550, 0, 0, 0, 1, 1, 0);
        chk("R3 read blocked", t_valid, 0);
        step();
        chk("R6 pulse one cycle each", nmi_req, 1);
        chk("R4 zero read rvalid", m_rvalid, 1);
        chk("R4 zero read data", m_rdata, 0);
        chk("R8 first addr kept", viol_addr, 32'h4440);
        step();
        chk("R6 pulse ends", nmi_req, 0);
        cfg_viol_rst = 1'b1;
        put(32'h6660, 1, 0, 0, 1, 1, 0);
        step();
        chk("R6 rst pulse", rst_req, 1);
        chk("R6 nmi quiet", nmi_req, 0);
        cfg_viol_rst = 1'b0;
        step();
        chk("R6 rst pulse ends", rst_req, 0);
    endtask

    task automatic t_exempt();
        put(32'h7770, 1, 32'h9, 0, 1, 1, 1);
        chk("R5 exempt forwarded", t_valid, 1);
        step();
        chk("R5 no pulse", {nmi_req, rst_req}, 0);
    endtask

    task automatic t_burst();
        int pulses = 0;
        put(32'h8000, 1, 1, 0, 0, 0, 0);
        chk("R7 beat0 forwarded", t_valid, 1);
        step();
        put(32'h8004, 1, 2, 0, 0, 0, 0);
        chk("R7 beat1 forwarded", t_valid, 1);
        step();
        put(32'h8008, 1, 3, 0, 0, 1, 0);
        chk("R7 bad beat blocked", t_valid, 0);
        step();
        pulses += int'(nmi_req);
        put(32'h800C, 1, 4, 0, 0, 0, 0);
        chk("R7 beat3 absorbed", t_valid, 0);
        chk("R7 beat3 ready", m_ready, 1);
        step();
        pulses += int'(nmi_req);
        put(32'h8010, 0, 0, 0, 1, 1, 0);
        chk("R7 last beat absorbed", t_valid, 0);
        step();
        pulses += int'(nmi_req);
        chk("R7 last read zero", m_rdata, 0);
        chk("R7 single pulse", pulses, 1);
        put(32'h9000, 1, 5, 0, 1, 0, 0);
        chk("R7 abort ends after last", t_valid, 1);
        step();
        put(32'hA000, 1, 6, 0, 0, 1, 0);
        chk("R7 bad first beat", t_valid, 0);
        step();
        put(32'hA004, 1, 7, 0, 1, 0, 0);
        chk("R7 bad start forwards nothing", t_valid, 0);
        step();
    endtask

    task automatic t_clear();
        viol_clr = 1'b1;
        put(32'hB0B0, 1, 0, 0, 1, 1, 0);
        step();
        chk("R8 clear+event keeps seen", viol_seen, 1);
        chk("R8 clear+event new addr", viol_addr, 32'hB0B0);
        viol_clr = 1'b1;
        step();
        chk("R8 clear alone", viol_seen, 0);
        put(32'hC0C0, 0, 0, 0, 1, 1, 0);
        step();
        chk("R8 recapture", viol_addr, 32'hC0C0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog act=1 exp=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_legal();
        t_illegal();
        t_exempt();
        t_burst();
        t_clear();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule